// File: doc/BRIEF.md
# Register Rename Map with Free Tag Pool

This block turns the architectural register names of a decoded instruction into physical register tags. It accepts at most one instruction per cycle, in program order. Each source name is looked up in a map table, and a destination that writes a register is given a fresh physical tag taken from a pool of unused tags. The map entry for that destination then points at the new tag. The tag the entry held before is returned with the result, so that the retire logic can hand it back to the pool once the instruction commits.

The physical pool is larger than the architectural register set. At reset every architectural register maps to the physical register with the same index, and the remaining tags sit in the pool in ascending order. A marked instruction takes a snapshot of the map and of the pool read position once its own update is applied. A later restore request puts both back, which throws away every rename made after the mark. When the pool is empty, an instruction that needs a destination is held off with a stall, and nothing changes.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. The pool hands out tags NUM_ARCH, NUM_ARCH+1, ... up to NUM_PHYS-1, in that order.
- R2: Source tags come from the map as it stood before the instruction. A source that names the instruction's own destination gets the old tag, not the new one.
- R3: An accepted instruction with `dec_has_dst` high receives the tag at the front of the pool. Tags leave the pool in the order they entered it.
- R4: `out_prev_tag` is the tag the destination entry held before the instruction, and it always differs from `out_dst_tag`.
- R5: An instruction with `dec_has_dst` low takes no tag and leaves the map unchanged. Its result shows `out_has_dst` = 0 and `out_dst_tag` = `out_prev_tag` = 0.
- R6: `stall` is high whenever `dec_valid` and `dec_has_dst` are high and the pool is empty. A stalled instruction is not accepted and changes neither map nor pool. An instruction without a destination still proceeds while the pool is empty.
- R7: A cycle with `cmt_valid` high appends `cmt_tag` to the back of the pool. A tag committed in the same cycle as a stalled decode does not lift that stall. It can be allocated from the next cycle on.
- R8: An accepted instruction with `dec_mark` high records a snapshot of the map that includes its own remap, and of the pool position just after its own allocation.
- R9: While `restore` is high, the map and the pool read position return to the last snapshot, or to the reset state if no snapshot was taken. Any decode in that cycle is dropped. A commit in that cycle still adds its tag to the pool.
- R10: Results are registered. The output fields show an accepted instruction in the cycle after acceptance with `out_valid` high. In any other cycle `out_valid` and all tag fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | An instruction is offered for renaming |
| dec_src_a | input | AW | First source architectural register |
| dec_src_b | input | AW | Second source architectural register |
| dec_dst | input | AW | Destination architectural register |
| dec_has_dst | input | 1 | Instruction writes a register |
| dec_mark | input | 1 | Take a snapshot at this instruction |
| cmt_valid | input | 1 | Return a tag to the pool |
| cmt_tag | input | TW | Tag being returned |
| restore | input | 1 | Roll back to the last snapshot |
| stall | output | 1 | Offered instruction cannot be accepted |
| out_valid | output | 1 | Registered result is present |
| out_src_a_tag | output | TW | Physical tag of first source |
| out_src_b_tag | output | TW | Physical tag of second source |
| out_has_dst | output | 1 | Result carries a newly allocated tag |
| out_dst_tag | output | TW | Newly allocated destination tag |
| out_prev_tag | output | TW | Destination's tag before this instruction |

## Verification
Some properties are checked on every cycle. The pool never pops when empty and never takes a tag when full. A fresh tag never equals the tag it replaces. A stalled or destination-free decode leaves the pool occupancy untouched, and a restore cycle yields no result. Other behaviour shows only in the bench scenarios, which compare every output against a queue-based model: the ascending reset order, the source read before the remap, the reuse of committed tags in first-in order, and the rewind of both map and pool to a snapshot while commits in flight are kept.

// File: rtl/rmu_pkg.sv
package rmu_pkg;

  // What the rename stage does with the current cycle's inputs
  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_DECODE  = 2'd1,
    ACT_STALL   = 2'd2,
    ACT_RESTORE = 2'd3
  } rmu_action_e;

endpackage

// File: rtl/rmu_free_fifo.sv
module rmu_free_fifo #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int TW = $clog2(NUM_PHYS),
  localparam int PW = TW + 1,
  localparam int NFREE = NUM_PHYS - NUM_ARCH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          mark,
  input  logic          restore,
  output logic [TW-1:0] head_tag,
  output logic [PW-1:0] count
);

  logic [TW-1:0] mem [NUM_PHYS];
  logic [PW-1:0] head, tail, ck_head, head_after_pop;

  assign head_after_pop = pop ? head + PW'(1) : head;
  assign count          = tail - head;
  assign head_tag       = mem[head[TW-1:0]];

  // storage: reset loads the tags above the architectural range
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PHYS; i++)
        mem[i] <= (i < NFREE) ? TW'(i + NUM_ARCH) : '0;
    end else if (push) begin
      mem[tail[TW-1:0]] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      tail    <= PW'(NFREE);
      ck_head <= '0;
    end else begin
      head <= restore ? ck_head : head_after_pop;
      if (push) tail <= tail + PW'(1);
      if (mark) ck_head <= head_after_pop;
    end
  end

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> count != PW'(NUM_PHYS));

endmodule

// File: rtl/rmu_map_table.sv
module rmu_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  input  logic [AW-1:0] rd_d,
  output logic [TW-1:0] tag_a,
  output logic [TW-1:0] tag_b,
  output logic [TW-1:0] tag_d,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_tag,
  input  logic          mark,
  input  logic          restore
);

  logic [TW-1:0] live [NUM_ARCH];
  logic [TW-1:0] snap [NUM_ARCH];

  // reads see the table before this cycle's write
  assign tag_a = live[rd_a];
  assign tag_b = live[rd_b];
  assign tag_d = live[rd_d];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_entry
    logic          hit;
    logic [TW-1:0] upd;
    assign hit = wr_en && (wr_addr == AW'(g));
    assign upd = hit ? wr_tag : live[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        live[g] <= TW'(g);
        snap[g] <= TW'(g);
      end else begin
        live[g] <= restore ? snap[g] : upd;
        if (mark) snap[g] <= upd;
      end
    end
  end

  // R8
  mark_excl_chk: assert property (@(posedge clk) disable iff (rst)
    mark |-> !restore);

endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit
  import rmu_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS),
  localparam int PW = TW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic [AW-1:0] dec_dst,
  input  logic          dec_has_dst,
  input  logic          dec_mark,
  input  logic          cmt_valid,
  input  logic [TW-1:0] cmt_tag,
  input  logic          restore,
  output logic          stall,
  output logic          out_valid,
  output logic [TW-1:0] out_src_a_tag,
  output logic [TW-1:0] out_src_b_tag,
  output logic          out_has_dst,
  output logic [TW-1:0] out_dst_tag,
  output logic [TW-1:0] out_prev_tag
);

  logic [PW-1:0] free_count;
  logic [TW-1:0] head_tag, map_a, map_b, map_d;
  logic          accept, alloc, take_snap;
  rmu_action_e   act;

  assign stall = dec_valid && dec_has_dst && (free_count == '0);

  always_comb begin
    if (restore)         act = ACT_RESTORE;
    else if (!dec_valid) act = ACT_IDLE;
    else if (stall)      act = ACT_STALL;
    else                 act = ACT_DECODE;
  end

  assign accept    = (act == ACT_DECODE);
  assign alloc     = accept && dec_has_dst;
  assign take_snap = accept && dec_mark;

  rmu_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk     (clk),
    .rst     (rst),
    .rd_a    (dec_src_a),
    .rd_b    (dec_src_b),
    .rd_d    (dec_dst),
    .tag_a   (map_a),
    .tag_b   (map_b),
    .tag_d   (map_d),
    .wr_en   (alloc),
    .wr_addr (dec_dst),
    .wr_tag  (head_tag),
    .mark    (take_snap),
    .restore (restore)
  );

  rmu_free_fifo #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_pool (
    .clk      (clk),
    .rst      (rst),
    .pop      (alloc),
    .push     (cmt_valid),
    .push_tag (cmt_tag),
    .mark     (take_snap),
    .restore  (restore),
    .head_tag (head_tag),
    .count    (free_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_src_a_tag <= '0;
      out_src_b_tag <= '0;
      out_has_dst   <= 1'b0;
      out_dst_tag   <= '0;
      out_prev_tag  <= '0;
    end else begin
      out_valid     <= accept;
      out_src_a_tag <= accept ? map_a : '0;
      out_src_b_tag <= accept ? map_b : '0;
      out_has_dst   <= alloc;
      out_dst_tag   <= alloc ? head_tag : '0;
      out_prev_tag  <= alloc ? map_d : '0;
    end
  end

  // R4
  fresh_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_has_dst) |-> (out_dst_tag != out_prev_tag));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !cmt_valid && !restore) |=> $stable(free_count));

  // R5
  no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_has_dst && !cmt_valid && !restore) |=> $stable(free_count));

  // R9
  restore_drop_chk: assert property (@(posedge clk) disable iff (rst)
    restore |=> !out_valid);

endmodule

// File: tb/rename_map_unit_bench.sv
module rename_map_unit_bench;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int AW = $clog2(NA);
  localparam int TW = $clog2(NP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 0, dec_has_dst = 0, dec_mark = 0, cmt_valid = 0, restore = 0;
  logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic [TW-1:0] cmt_tag = '0;
  logic stall, out_valid, out_has_dst;
  logic [TW-1:0] out_src_a_tag, out_src_b_tag, out_dst_tag, out_prev_tag;

  always #5 clk = ~clk;

  rename_map_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP)) u_rename_map_unit (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_src_a(dec_src_a),
    .dec_src_b(dec_src_b), .dec_dst(dec_dst), .dec_has_dst(dec_has_dst),
    .dec_mark(dec_mark), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
    .restore(restore), .stall(stall), .out_valid(out_valid),
    .out_src_a_tag(out_src_a_tag), .out_src_b_tag(out_src_b_tag),
    .out_has_dst(out_has_dst), .out_dst_tag(out_dst_tag),
    .out_prev_tag(out_prev_tag)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  string tag_ctx = "R1";

  // reference model state
  int map_m [NA];
  int snap_m [NA];
  int free_q [$];
  int popped [$];
  int prevq [$];
  int ck_len;
  bit ck_live;
  int e_valid, e_a, e_b, e_has, e_dst, e_prev;

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag_ctx, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NA; i++) begin map_m[i] = i; snap_m[i] = i; end
      free_q = {};
      for (int i = NA; i < NP; i++) free_q.push_back(i);
      popped = {}; prevq = {}; ck_len = 0; ck_live = 0;
      e_valid = 0; e_a = 0; e_b = 0; e_has = 0; e_dst = 0; e_prev = 0;
    end else begin
      bit st, acc;
      st  = dec_valid && dec_has_dst && (free_q.size() == 0);
      acc = dec_valid && !st && !restore;
      e_valid = acc; e_a = 0; e_b = 0; e_has = 0; e_dst = 0; e_prev = 0;
      if (acc) begin
        e_a = map_m[dec_src_a];
        e_b = map_m[dec_src_b];
        if (dec_has_dst) begin
          e_has  = 1;
          e_dst  = free_q.pop_front();
          popped.push_back(e_dst);
          e_prev = map_m[dec_dst];
          map_m[dec_dst] = e_dst;
          prevq.push_back(e_prev);
        end
        if (dec_mark) begin
          snap_m = map_m; popped = {}; ck_len = prevq.size(); ck_live = 1;
        end
      end
      if (cmt_valid) begin
        free_q.push_back(int'(cmt_tag));
        void'(prevq.pop_front());
        if (ck_len > 0) ck_len--;
      end
      if (restore) begin
        map_m = snap_m;
        free_q = {popped, free_q};
        popped = {};
        while (prevq.size() > ck_len) void'(prevq.pop_back());
        ck_live = 0;
      end
    end
  end

  // registered outputs compared every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(out_valid == e_valid[0], "R10 out_valid", int'(out_valid), e_valid);
      chk(int'(out_src_a_tag) == e_a, "R2 src_a", int'(out_src_a_tag), e_a);
      chk(int'(out_src_b_tag) == e_b, "R2 src_b", int'(out_src_b_tag), e_b);
      chk(out_has_dst == e_has[0], "R5 has_dst", int'(out_has_dst), e_has);
      chk(int'(out_dst_tag) == e_dst, "R3 dst_tag", int'(out_dst_tag), e_dst);
      chk(int'(out_prev_tag) == e_prev, "R4 prev_tag", int'(out_prev_tag), e_prev);
    end
  end

  function automatic bit commit_ok();
    return prevq.size() > 0 && (!ck_live || ck_len > 0);
  endfunction

  task automatic drive(bit dv, int sa, int sb, int d, bit hd, bit mk, bit cv, bit rs);
    bit exp_st;
    @(negedge clk);
    #1;
    dec_valid = dv; dec_src_a = AW'(sa); dec_src_b = AW'(sb); dec_dst = AW'(d);
    dec_has_dst = hd; dec_mark = mk; restore = rs;
    cmt_valid = cv && commit_ok();
    cmt_tag = cmt_valid ? TW'(prevq[0]) : '0;
    #1;
    exp_st = dv && hd && (free_q.size() == 0);
    chk(stall == exp_st, "R6 stall", int'(stall), int'(exp_st));
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state on the outputs
    tag_ctx = "R1";
    #1;
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    chk(stall == 1'b0, "R1 reset stall", int'(stall), 0);
    // R1 R3 R4: ascending allocation from reset, identity sources
    drive(1, 0, 2, 1, 1, 0, 0, 0);
    drive(1, 3, 4, 2, 1, 0, 0, 0);
    // R2: source equal to destination reads the old tag
    tag_ctx = "R2";
    drive(1, 1, 1, 1, 1, 0, 0, 0);
    // R5: no destination
    tag_ctx = "R5";
    drive(1, 1, 2, 5, 0, 0, 0, 0);
    idle();
    // R6: drain the pool, then stall; no-dst still proceeds
    tag_ctx = "R6";
    for (int k = 0; k < 5; k++) drive(1, k, k + 1, k + 3, 1, 0, 0, 0);
    drive(1, 0, 1, 4, 1, 0, 0, 0);
    drive(1, 0, 1, 4, 1, 0, 0, 0);
    drive(1, 6, 7, 0, 0, 0, 0, 0);
    // R7: commit alongside a stalled decode, then the tag is reusable
    tag_ctx = "R7";
    drive(1, 2, 3, 6, 1, 0, 1, 0);
    drive(1, 2, 3, 6, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 0);
    // R8: mark an allocating instruction, rename further
    tag_ctx = "R8";
    drive(1, 1, 2, 3, 1, 1, 0, 0);
    drive(1, 3, 3, 3, 1, 0, 0, 0);
    drive(1, 0, 3, 7, 1, 0, 0, 0);
    // R9: restore with a dropped decode and a live commit
    tag_ctx = "R9";
    drive(1, 3, 7, 0, 1, 0, 1, 1);
    drive(1, 3, 7, 3, 1, 0, 0, 0);
    idle();
    // mixed traffic under the same rules
    tag_ctx = "R3";
    for (int c = 0; c < 400; c++) begin
      bit dv, hd, mk, cv, rs;
      dv = ($urandom_range(0, 9) < 8);
      hd = ($urandom_range(0, 9) < 7);
      mk = !ck_live && ($urandom_range(0, 9) == 0);
      rs = ck_live && ($urandom_range(0, 11) == 0);
      cv = ($urandom_range(0, 9) < 4);
      drive(dv, $urandom_range(0, NA - 1), $urandom_range(0, NA - 1),
            $urandom_range(0, NA - 1), hd, mk, cv, rs);
    end
    idle();
    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", tag_ctx, 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule